// File: doc/BRIEF.md
# Isochronous Frame Transmit Scheduler

This block decides, clock by clock, who may transmit on a shared serial link whose time is cut into frames of a fixed length. Each frame opens with a timing indicator. Reserved isochronous channels are then served back to back in ascending table index order. Only the time that remains after that goes to best-effort asynchronous packets. An asynchronous packet is granted only when the whole packet fits before the next frame boundary; otherwise it waits for the next frame.

A channel allocation table of up to `NUM_CH` entries is loaded in one cycle. Each entry holds an enable, a channel number and a slot length in clock cycles. The load is checked at once: if the enabled slot lengths add up to more than a set share of the frame, the load is refused and the running table is kept. An accepted table is held aside and takes over at the next frame boundary. A reserved channel that has no packet ready when its turn comes takes no time, so the following channel, or asynchronous traffic, starts at once. Every grant comes with a one-cycle packet header carrying the kind of packet and its channel number.

The frame length is a count of clock cycles. The default is 12500 cycles, which is 125 µs at 100 MHz.

Top module: `iso_frame_sched`

## Requirements
- R1: While `rst_ni` is low, `frame_start_o` and `ti_active_o` are 1, no grant is given and `busy_o` is 0. The first cycle after release is cycle 0 of a frame, and the allocation table is empty.
- R2: `frame_start_o` is 1 on cycle 0 of every frame and 0 on every other cycle, so it repeats every `FRAME_CYCLES` cycles.
- R3: For cycles 0 to `TI_CYCLES`-1 of each frame, `ti_active_o` is 1 and nothing is granted. On cycle 0 a header is emitted with `hdr_valid_o`=1 and `hdr_kind_o`=1 (timing).
- R4: Enabled channels with a nonzero length whose `iso_ready_i` bit is 1 are granted in ascending index order. The first grant comes on cycle `TI_CYCLES`, and each later grant comes exactly when the previous slot ends. A grant is a one-cycle pulse on bit i of `iso_grant_o`.
- R5: The cycle of an isochronous grant carries a header with `hdr_kind_o`=2 and `hdr_ch_id_o` equal to that entry's channel number.
- R6: A reserved channel that is not ready takes no cycles in that frame. The next ready channel, or an asynchronous packet, starts in the cycle where that channel's slot would have started.
- R7: An asynchronous grant is given only when no isochronous channel is left to serve, `async_pending_i` is 1, and `async_len_i` is between 1 and the number of cycles left in the frame, counting the current one. Its header has `hdr_kind_o`=3 and `hdr_ch_id_o` all ones. Back-to-back packets follow without gaps while they fit.
- R8: At most one grant is given per cycle. `busy_o` is 1 on exactly the cycles a granted packet occupies, and no grant is given while a packet is still running.
- R9: When `cfg_load_i` is 1, either `cfg_accept_o` or `cfg_reject_o` pulses in the same cycle. The load is rejected when the sum of the enabled lengths exceeds min(`FRAME_CYCLES`*`ISO_PCT`/100, `FRAME_CYCLES`-`TI_CYCLES`); a sum equal to that limit is accepted. A rejected load changes nothing. An accepted table governs from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load the allocation table from the cfg inputs |
| cfg_en_i | input | NUM_CH | Entry enable per table index |
| cfg_ch_id_i | input | NUM_CH*ID_W | Channel number per entry, entry i at bits [i*ID_W +: ID_W] |
| cfg_len_i | input | NUM_CH*LEN_W | Slot length in cycles per entry, entry i at bits [i*LEN_W +: LEN_W] |
| cfg_accept_o | output | 1 | Load accepted |
| cfg_reject_o | output | 1 | Load refused, isochronous sum over limit |
| iso_ready_i | input | NUM_CH | Packet ready per table index |
| async_pending_i | input | 1 | Asynchronous queue not empty |
| async_len_i | input | LEN_W | Length in cycles of the head asynchronous packet |
| frame_start_o | output | 1 | Cycle 0 of a frame |
| ti_active_o | output | 1 | Timing indicator is being sent |
| iso_grant_o | output | NUM_CH | One-cycle grant per table index |
| async_grant_o | output | 1 | One-cycle asynchronous grant |
| busy_o | output | 1 | A granted packet occupies the link |
| hdr_valid_o | output | 1 | Header emitted this cycle |
| hdr_kind_o | output | 2 | 1 timing, 2 isochronous, 3 asynchronous |
| hdr_ch_id_o | output | ID_W | Channel number carried by the header |

## Verification
The hardest case to reach is an asynchronous packet that ends exactly on the frame boundary, next to one that is a single cycle too long. Hitting it requires the bench to place the end of the isochronous phase precisely, through the table contents and the ready mask. Directed frames do this by choosing slot lengths and a packet length that add up to the frame length, and then that length plus one. A table whose sum equals the limit is loaded, followed by one just over it. Random frames then vary the tables, ready masks and packet lengths, and each frame is checked against a schedule the bench builds for it.

// File: rtl/iso_sched_pkg.sv
package iso_sched_pkg;
  typedef enum logic [1:0] {
    HDR_NONE   = 2'd0,
    HDR_TIMING = 2'd1,
    HDR_ISO    = 2'd2,
    HDR_ASYNC  = 2'd3
  } hdr_kind_e;
endpackage

// File: rtl/iso_frame_timer.sv
module iso_frame_timer #(
  parameter int FRAME_CYCLES = 12500,
  parameter int TI_CYCLES    = 16,
  parameter int CNT_W        = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             start_o,
  output logic             last_o,
  output logic             ti_o,
  output logic [CNT_W-1:0] left_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign start_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CNT_W'(FRAME_CYCLES - 1));
  assign ti_o    = (cnt_q <  CNT_W'(TI_CYCLES));
  // cycles left in the frame, current one included
  assign left_o  = CNT_W'(FRAME_CYCLES) - cnt_q;
endmodule

// File: rtl/iso_alloc_table.sv
module iso_alloc_table #(
  parameter int NUM_CH = 8,
  parameter int ID_W   = 6,
  parameter int LEN_W  = 16,
  parameter int LIMIT  = 10000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    swap_i,
  input  logic [NUM_CH-1:0]       en_i,
  input  logic [NUM_CH*ID_W-1:0]  id_i,
  input  logic [NUM_CH*LEN_W-1:0] len_i,
  output logic                    accept_o,
  output logic                    reject_o,
  output logic [NUM_CH-1:0]       act_en_o,
  output logic [NUM_CH*ID_W-1:0]  act_id_o,
  output logic [NUM_CH*LEN_W-1:0] act_len_o
);
  logic [NUM_CH-1:0]       pend_en_q, act_en_q;
  logic [NUM_CH*ID_W-1:0]  pend_id_q, act_id_q;
  logic [NUM_CH*LEN_W-1:0] pend_len_q, act_len_q;
  logic [31:0]             sum;
  logic                    fits;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (en_i[i]) sum = sum + 32'(len_i[i*LEN_W +: LEN_W]);
  end

  assign fits     = (sum <= 32'(LIMIT));
  assign accept_o = load_i & fits;
  assign reject_o = load_i & ~fits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_en_q  <= '0;
      pend_id_q  <= '0;
      pend_len_q <= '0;
    end else if (accept_o) begin
      pend_en_q  <= en_i;
      pend_id_q  <= id_i;
      pend_len_q <= len_i;
    end
  end

  // new table governs from the frame after the one it was loaded in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_en_q  <= '0;
      act_id_q  <= '0;
      act_len_q <= '0;
    end else if (swap_i) begin
      act_en_q  <= accept_o ? en_i  : pend_en_q;
      act_id_q  <= accept_o ? id_i  : pend_id_q;
      act_len_q <= accept_o ? len_i : pend_len_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_en
    assign act_en_o[i] = act_en_q[i] & (act_len_q[i*LEN_W +: LEN_W] != '0);
  end
  assign act_id_o  = act_id_q;
  assign act_len_o = act_len_q;
endmodule

// File: rtl/iso_slot_picker.sv
module iso_slot_picker #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = 3
) (
  input  logic [NUM_CH-1:0] cand_i,
  output logic              any_o,
  output logic [NUM_CH-1:0] sel_oh_o,
  output logic [NUM_CH-1:0] past_o,
  output logic [IDX_W-1:0]  sel_idx_o
);
  // past_o[i]: some candidate sits below index i
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pick
    if (i == 0) begin : g_lo
      assign past_o[i] = 1'b0;
    end else begin : g_hi
      assign past_o[i] = past_o[i-1] | cand_i[i-1];
    end
    assign sel_oh_o[i] = cand_i[i] & ~past_o[i];
  end

  assign any_o = |cand_i;

  always_comb begin
    sel_idx_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (sel_oh_o[i]) sel_idx_o = sel_idx_o | IDX_W'(i);
  end
endmodule

// File: rtl/iso_frame_sched.sv
module iso_frame_sched
  import iso_sched_pkg::*;
#(
  parameter int NUM_CH       = 8,
  parameter int ID_W         = 6,
  parameter int LEN_W        = 16,
  parameter int FRAME_CYCLES = 12500,
  parameter int TI_CYCLES    = 16,
  parameter int ISO_PCT      = 80
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_load_i,
  input  logic [NUM_CH-1:0]       cfg_en_i,
  input  logic [NUM_CH*ID_W-1:0]  cfg_ch_id_i,
  input  logic [NUM_CH*LEN_W-1:0] cfg_len_i,
  output logic                    cfg_accept_o,
  output logic                    cfg_reject_o,
  input  logic [NUM_CH-1:0]       iso_ready_i,
  input  logic                    async_pending_i,
  input  logic [LEN_W-1:0]        async_len_i,
  output logic                    frame_start_o,
  output logic                    ti_active_o,
  output logic [NUM_CH-1:0]       iso_grant_o,
  output logic                    async_grant_o,
  output logic                    busy_o,
  output logic                    hdr_valid_o,
  output logic [1:0]              hdr_kind_o,
  output logic [ID_W-1:0]         hdr_ch_id_o
);
  localparam int CNT_W     = $clog2(FRAME_CYCLES + 1);
  localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int LIMIT_RAW = (FRAME_CYCLES * ISO_PCT) / 100;
  localparam int ROOM      = FRAME_CYCLES - TI_CYCLES;
  localparam int ISO_LIMIT = (LIMIT_RAW < ROOM) ? LIMIT_RAW : ROOM;
  localparam int CMP_W     = (LEN_W > CNT_W) ? LEN_W : CNT_W;

  logic                    f_start, f_last, f_ti;
  logic [CNT_W-1:0]        f_left;
  logic [NUM_CH-1:0]       act_en;
  logic [NUM_CH*ID_W-1:0]  act_id;
  logic [NUM_CH*LEN_W-1:0] act_len;
  logic [NUM_CH-1:0]       cand, sel_oh, past;
  logic [IDX_W-1:0]        sel_idx;
  logic                    any_cand;

  logic [LEN_W-1:0]  busy_q;
  logic [NUM_CH-1:0] done_q;
  logic              iso_open_q;
  logic              free, iso_go, async_fit, async_go;
  logic [LEN_W-1:0]  sel_len;
  logic [CMP_W-1:0]  alen_x, left_x;

  iso_frame_timer #(
    .FRAME_CYCLES(FRAME_CYCLES), .TI_CYCLES(TI_CYCLES), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i, .rst_ni,
    .start_o(f_start), .last_o(f_last), .ti_o(f_ti), .left_o(f_left)
  );

  iso_alloc_table #(
    .NUM_CH(NUM_CH), .ID_W(ID_W), .LEN_W(LEN_W), .LIMIT(ISO_LIMIT)
  ) u_table (
    .clk_i, .rst_ni,
    .load_i(cfg_load_i), .swap_i(f_last),
    .en_i(cfg_en_i), .id_i(cfg_ch_id_i), .len_i(cfg_len_i),
    .accept_o(cfg_accept_o), .reject_o(cfg_reject_o),
    .act_en_o(act_en), .act_id_o(act_id), .act_len_o(act_len)
  );

  assign cand = act_en & iso_ready_i & ~done_q & {NUM_CH{iso_open_q}};

  iso_slot_picker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .cand_i(cand), .any_o(any_cand), .sel_oh_o(sel_oh),
    .past_o(past), .sel_idx_o(sel_idx)
  );

  assign sel_len   = act_len[sel_idx*LEN_W +: LEN_W];
  assign alen_x    = CMP_W'(async_len_i);
  assign left_x    = CMP_W'(f_left);
  assign free      = ~f_ti & (busy_q == '0);
  assign iso_go    = free & any_cand;
  assign async_fit = (async_len_i != '0) & (alen_x <= left_x);
  assign async_go  = free & ~any_cand & async_pending_i & async_fit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= '0;
      done_q     <= '0;
      iso_open_q <= 1'b1;
    end else if (f_last) begin
      busy_q     <= '0;
      done_q     <= '0;
      iso_open_q <= 1'b1;
    end else if (iso_go) begin
      busy_q <= sel_len - 1'b1;
      done_q <= done_q | ~past;   // selected index and all below it
    end else if (free) begin
      iso_open_q <= 1'b0;         // nothing left to serve: close iso phase
      if (async_go) busy_q <= async_len_i - 1'b1;
    end else if (busy_q != '0) begin
      busy_q <= busy_q - 1'b1;
    end
  end

  assign frame_start_o = f_start;
  assign ti_active_o   = f_ti;
  assign iso_grant_o   = iso_go ? sel_oh : '0;
  assign async_grant_o = async_go;
  assign busy_o        = (busy_q != '0) | iso_go | async_go;
  assign hdr_valid_o   = f_start | iso_go | async_go;

  always_comb begin
    hdr_kind_o  = HDR_NONE;
    hdr_ch_id_o = '0;
    if (f_start) begin
      hdr_kind_o = HDR_TIMING;
    end else if (iso_go) begin
      hdr_kind_o  = HDR_ISO;
      hdr_ch_id_o = act_id[sel_idx*ID_W +: ID_W];
    end else if (async_go) begin
      hdr_kind_o  = HDR_ASYNC;
      hdr_ch_id_o = '1;
    end
  end
endmodule

// File: rtl/iso_frame_sched_chk.sv
module iso_frame_sched_chk #(
  parameter int NUM_CH       = 8,
  parameter int LEN_W        = 16,
  parameter int FRAME_CYCLES = 12500
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_load_i,
  input logic              cfg_accept_o,
  input logic              cfg_reject_o,
  input logic              async_pending_i,
  input logic [LEN_W-1:0]  async_len_i,
  input logic              frame_start_o,
  input logic              ti_active_o,
  input logic [NUM_CH-1:0] iso_grant_o,
  input logic              async_grant_o,
  input logic              hdr_valid_o,
  input logic [1:0]        hdr_kind_o
);
  int unsigned cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cyc <= 0;
    else if (cyc == FRAME_CYCLES - 1)  cyc <= 0;
    else                               cyc <= cyc + 1;
  end

  assert_frame_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o == (cyc == 0));

  assert_quiet_ti_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_active_o |-> (iso_grant_o == '0 && !async_grant_o));

  assert_iso_hdr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_grant_o != '0) |-> (hdr_valid_o && hdr_kind_o == 2'd2));

  assert_async_fits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    async_grant_o |-> (async_pending_i && async_len_i != '0 &&
                       32'(async_len_i) <= FRAME_CYCLES - cyc));

  assert_one_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({iso_grant_o, async_grant_o}));

  assert_load_answer_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_load_i ? (cfg_accept_o ^ cfg_reject_o) : !(cfg_accept_o || cfg_reject_o));
endmodule

bind iso_frame_sched iso_frame_sched_chk #(
  .NUM_CH(NUM_CH), .LEN_W(LEN_W), .FRAME_CYCLES(FRAME_CYCLES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_load_i(cfg_load_i),
  .cfg_accept_o(cfg_accept_o), .cfg_reject_o(cfg_reject_o),
  .async_pending_i(async_pending_i), .async_len_i(async_len_i),
  .frame_start_o(frame_start_o), .ti_active_o(ti_active_o),
  .iso_grant_o(iso_grant_o), .async_grant_o(async_grant_o),
  .hdr_valid_o(hdr_valid_o), .hdr_kind_o(hdr_kind_o)
);

// File: tb/iso_frame_sched_test.sv
module iso_frame_sched_test;
  localparam int CLK_P  = 10;
  localparam int NCH    = 8;
  localparam int IDW    = 6;
  localparam int LW     = 16;
  localparam int FRAME  = 120;
  localparam int TI     = 4;
  localparam int PCT    = 50;
  localparam int LIMIT  = 60;   // min(120*50/100, 120-4)
  localparam int LOAD_C = 50;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_load_i = 1'b0;
  logic [NCH-1:0] cfg_en_i;
  logic [NCH*IDW-1:0] cfg_ch_id_i;
  logic [NCH*LW-1:0] cfg_len_i;
  logic cfg_accept_o, cfg_reject_o;
  logic [NCH-1:0] iso_ready_i = '0;
  logic async_pending_i = 1'b0;
  logic [LW-1:0] async_len_i = '0;
  logic frame_start_o, ti_active_o, async_grant_o, busy_o, hdr_valid_o;
  logic [NCH-1:0] iso_grant_o;
  logic [1:0] hdr_kind_o;
  logic [IDW-1:0] hdr_ch_id_o;

  // bench model of the table
  logic [NCH-1:0] nx_en = '0, pd_en = '0, ac_en = '0;
  logic [IDW-1:0] nx_id [NCH];
  logic [IDW-1:0] pd_id [NCH];
  logic [IDW-1:0] ac_id [NCH];
  int nx_len [NCH];
  int pd_len [NCH];
  int ac_len [NCH];

  int e_iso [FRAME];
  bit e_async [FRAME];
  bit e_busy [FRAME];

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  always_comb begin
    cfg_en_i = nx_en;
    for (int i = 0; i < NCH; i++) begin
      cfg_ch_id_i[i*IDW +: IDW] = nx_id[i];
      cfg_len_i[i*LW +: LW]     = LW'(nx_len[i]);
    end
  end

  iso_frame_sched #(
    .NUM_CH(NCH), .ID_W(IDW), .LEN_W(LW),
    .FRAME_CYCLES(FRAME), .TI_CYCLES(TI), .ISO_PCT(PCT)
  ) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nx_sum();
    int s = 0;
    for (int i = 0; i < NCH; i++) if (nx_en[i]) s += nx_len[i];
    return s;
  endfunction

  function automatic void build(input logic [NCH-1:0] rdy, input bit pend, input int alen);
    int t = TI;
    for (int c = 0; c < FRAME; c++) begin e_iso[c] = -1; e_async[c] = 0; e_busy[c] = 0; end
    for (int i = 0; i < NCH; i++)
      if (ac_en[i] && ac_len[i] > 0 && rdy[i]) begin
        e_iso[t] = i;
        for (int k = t; k < t + ac_len[i]; k++) e_busy[k] = 1;
        t += ac_len[i];
      end
    if (pend && alen > 0)
      while (t + alen <= FRAME) begin
        e_async[t] = 1;
        for (int k = t; k < t + alen; k++) e_busy[k] = 1;
        t += alen;
      end
  endfunction

  task automatic run_frame(input logic [NCH-1:0] rdy, input bit pend, input int alen,
                           input bit do_load, input string tag);
    bit acc;
    build(rdy, pend, alen);
    for (int c = 0; c < FRAME; c++) begin
      iso_ready_i     = rdy;
      async_pending_i = pend;
      async_len_i     = LW'(alen);
      cfg_load_i      = do_load && (c == LOAD_C);
      #1;
      chk(frame_start_o == (c == 0), "R2 frame_start", frame_start_o, c == 0);
      chk(ti_active_o == (c < TI), "R3 ti_active", ti_active_o, c < TI);
      if (c == 0)
        chk(hdr_valid_o && hdr_kind_o == 2'd1, "R3 timing header", hdr_kind_o, 1);
      chk(iso_grant_o == (e_iso[c] >= 0 ? NCH'(1) << e_iso[c] : '0),
          {"R4 iso grant ", tag}, iso_grant_o, e_iso[c] >= 0 ? 1 << e_iso[c] : 0);
      if (e_iso[c] >= 0) begin
        chk(hdr_valid_o && hdr_kind_o == 2'd2, "R5 iso header kind", hdr_kind_o, 2);
        chk(hdr_ch_id_o == ac_id[e_iso[c]], "R5 iso header id", hdr_ch_id_o, ac_id[e_iso[c]]);
      end
      chk(async_grant_o == e_async[c], {"R7 async grant ", tag}, async_grant_o, e_async[c]);
      if (e_async[c])
        chk(hdr_kind_o == 2'd3 && hdr_ch_id_o == '1, "R7 async header", hdr_ch_id_o, 63);
      chk(busy_o == e_busy[c], "R8 busy", busy_o, e_busy[c]);
      if (cfg_load_i) begin
        acc = (nx_sum() <= LIMIT);
        chk(cfg_accept_o == acc && cfg_reject_o == !acc, "R9 load verdict",
            {cfg_accept_o, cfg_reject_o}, {acc, !acc});
        if (acc) begin
          pd_en = nx_en;
          for (int i = 0; i < NCH; i++) begin pd_id[i] = nx_id[i]; pd_len[i] = nx_len[i]; end
        end
      end else begin
        chk(!cfg_accept_o && !cfg_reject_o, "R9 idle verdict", {cfg_accept_o, cfg_reject_o}, 0);
      end
      @(negedge clk_i);
    end
    ac_en = pd_en;
    for (int i = 0; i < NCH; i++) begin ac_id[i] = pd_id[i]; ac_len[i] = pd_len[i]; end
  endtask

  task automatic set_nx(input logic [NCH-1:0] en, input int l0, l1, l2, l3, l4, l5, l6, l7);
    int l [NCH];
    l = '{l0, l1, l2, l3, l4, l5, l6, l7};
    nx_en = en;
    for (int i = 0; i < NCH; i++) begin nx_len[i] = l[i]; nx_id[i] = IDW'(3 * i + 7); end
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      nx_id[i] = '0; pd_id[i] = '0; ac_id[i] = '0;
      nx_len[i] = 0; pd_len[i] = 0; ac_len[i] = 0;
    end
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk_i);
    #1;
    // R1: reset state
    chk(frame_start_o && ti_active_o, "R1 reset frame state", {frame_start_o, ti_active_o}, 3);
    chk(iso_grant_o == '0 && !async_grant_o && !busy_o, "R1 reset quiet",
        {iso_grant_o, async_grant_o, busy_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // table A: entries 0,2,3 lengths 10,20,5 -> sum 35
    set_nx(8'b0000_1101, 10, 0, 20, 5, 0, 0, 0, 0);
    run_frame('0, 1'b1, 10, 1'b1, "R1 empty table");
    // async 81 ends exactly at the boundary (4+35+81=120)
    run_frame('1, 1'b1, 81, 1'b0, "R7 exact fit");
    // 82 does not fit; load with sum 61 is refused
    set_nx(8'b0000_0011, 30, 31, 0, 0, 0, 0, 0, 0);
    run_frame('1, 1'b1, 82, 1'b1, "R7 one over, R9 reject");
    // R6: entry 2 not ready, its time goes to the rest; load sum == limit
    set_nx(8'b1111_0000, 0, 0, 0, 0, 15, 15, 15, 15);
    run_frame(8'b0000_1001, 1'b1, 20, 1'b1, "R6 unready slot freed");
    run_frame('1, 1'b1, 1, 1'b0, "R9 limit table, R8 back to back");
    run_frame('1, 1'b0, 5, 1'b0, "R7 no pending");
    run_frame(8'b1010_0000, 1'b1, 0, 1'b0, "R7 zero length");

    for (int f = 0; f < 30; f++) begin
      logic [NCH-1:0] en = NCH'($urandom);
      for (int i = 0; i < NCH; i++) begin
        nx_len[i] = 1 + ($urandom % 15);
        nx_id[i]  = IDW'($urandom);
      end
      nx_en = en;
      run_frame(NCH'($urandom), 1'($urandom), $urandom % 71, 1'($urandom), "random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule